// File: doc/BRIEF.md
# USB OUT Handshake Responder

This block chooses the handshake a device endpoint returns at the end of every OUT or SETUP data packet. The receive path pulses `pkt_end` when a data packet has been fully received. With it, the path supplies the token kind, the data PID seen, whether the CRC was good and the byte count. The endpoint control state arrives on static inputs: enable, endpoint NAK, global OUT NAK, stall, snoop, transfer type, expected data PID and maximum packet size. The free space in the receive FIFO is also an input.

One cycle after `pkt_end`, the block presents a one-cycle response. It carries a handshake code, a strobe that commits the packet to the FIFO and a strobe that flips the endpoint's data toggle. After a SETUP it also raises requests to set the endpoint NAK status and, on a control endpoint, to clear stall. The register that holds those bits applies the requests.

Top module: `usb_out_hs_resp`

## Requirements
- R1: All outputs are zero after reset and in every cycle not directly following a `pkt_end` cycle. The response for a packet appears for exactly one cycle, the clock cycle after `pkt_end`. `hs` encodes 00 none, 01 ACK, 10 NAK, 11 STALL.
- R2: A packet with a bad CRC (`crc_ok`=0) and snoop off gets no handshake and is not stored.
- R3: A packet with `pkt_len` greater than `max_pkt` gets no handshake and is not stored, whatever the snoop setting.
- R4: A SETUP packet (`tok_setup`=1) that passes R2 and R3 is ACKed and stored, whatever the NAK, global NAK, stall, enable or FIFO state. It raises `set_nak_req`, and it raises `clr_stall_req` when `ep_type` is 00 (control). It never toggles the PID.
- R5: On an isochronous endpoint (`ep_type`=01), an OUT packet never gets a handshake. It is stored when `fifo_free` >= `pkt_len` and dropped otherwise, and the PID never toggles.
- R6: On a non-isochronous endpoint, an OUT packet with `ep_stall`=1 gets STALL, even when any NAK source is also active.
- R7: Without stall, a non-isochronous OUT packet gets NAK and is not stored if `ep_enable`=0, `ep_nak`=1, `glob_out_nak`=1 or `fifo_free` < `pkt_len`.
- R8: On a bulk (10) or interrupt (11) endpoint with snoop off, an OUT packet whose `data_pid` (0 DATA0, 1 DATA1) differs from `exp_pid` is ACKed but not stored, and the PID does not toggle.
- R9: Any other OUT packet is ACKed and stored. `pid_toggle` fires with it only for bulk and interrupt endpoints.
- R10: With `snoop`=1, the CRC check and the data PID check are skipped for both OUT and SETUP packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_end | input | 1 | One-cycle strobe at the end of a data packet |
| tok_setup | input | 1 | 1 = SETUP token, 0 = OUT token |
| data_pid | input | 1 | Received data PID, 0 DATA0, 1 DATA1 |
| crc_ok | input | 1 | Packet CRC was good |
| pkt_len | input | LEN_W | Packet length in bytes |
| fifo_free | input | FREE_W | Free receive FIFO space in bytes |
| ep_enable | input | 1 | Endpoint enabled |
| ep_nak | input | 1 | Endpoint NAK status |
| glob_out_nak | input | 1 | Global OUT NAK |
| ep_stall | input | 1 | Endpoint stall |
| snoop | input | 1 | Skip packet correctness checks |
| ep_type | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| exp_pid | input | 1 | Expected data PID |
| max_pkt | input | LEN_W | Maximum packet size in bytes |
| hs | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| fifo_push | output | 1 | Commit the packet to the FIFO |
| pid_toggle | output | 1 | Flip the expected data PID |
| set_nak_req | output | 1 | Request to set endpoint NAK status |
| clr_stall_req | output | 1 | Request to clear endpoint stall |

## Verification
The embedded properties check the following on every cycle. Responses appear only after a packet end. SETUP is always ACKed and stored once its CRC and length pass. Stall beats every NAK source. A toggle always comes with an ACK and a push, and a push never comes with NAK or STALL. The precedence between CRC, length, isochronous handling, the NAK sources and the PID mismatch is shown only by the bench. It sweeps every combination of the control inputs against fitting, exact-fit, short-FIFO and oversize lengths, and compares all five outputs with an independent model.

// File: rtl/usb_out_hs_resp.sv
module usb_out_hs_resp #(
  parameter int LEN_W  = 11,
  parameter int FREE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_end,
  input  logic              tok_setup,
  input  logic              data_pid,
  input  logic              crc_ok,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              ep_enable,
  input  logic              ep_nak,
  input  logic              glob_out_nak,
  input  logic              ep_stall,
  input  logic              snoop,
  input  logic [1:0]        ep_type,
  input  logic              exp_pid,
  input  logic [LEN_W-1:0]  max_pkt,
  output logic [1:0]        hs,
  output logic              fifo_push,
  output logic              pid_toggle,
  output logic              set_nak_req,
  output logic              clr_stall_req
);
  localparam int CW = ((LEN_W > FREE_W) ? LEN_W : FREE_W) + 1;
  localparam logic [1:0] HS_NONE = 2'b00, HS_ACK = 2'b01, HS_NAK = 2'b10, HS_STALL = 2'b11;
  localparam logic [1:0] T_CTRL = 2'b00, T_ISO = 2'b01;

  logic [CW-1:0] len_x, free_x;
  logic fits, crc_pass, oversize, seq_ep, pid_bad, nak_any;
  logic [1:0] n_hs;
  logic n_push, n_tog, n_snak, n_cstl;

  assign len_x    = CW'(pkt_len);
  assign free_x   = CW'(fifo_free);
  assign fits     = free_x >= len_x;
  assign crc_pass = crc_ok | snoop;
  assign oversize = pkt_len > max_pkt;
  assign seq_ep   = ep_type[1];
  assign pid_bad  = seq_ep & ~snoop & (data_pid != exp_pid);
  assign nak_any  = ~ep_enable | ep_nak | glob_out_nak | ~fits;

  always_comb begin
    n_hs = HS_NONE; n_push = 1'b0; n_tog = 1'b0; n_snak = 1'b0; n_cstl = 1'b0;
    if (!pkt_end || !crc_pass || oversize) begin
      n_hs = HS_NONE;
    end else if (tok_setup) begin
      n_hs = HS_ACK; n_push = 1'b1; n_snak = 1'b1;
      n_cstl = (ep_type == T_CTRL);
    end else if (ep_type == T_ISO) begin
      n_push = fits;
    end else if (ep_stall) begin
      n_hs = HS_STALL;
    end else if (nak_any) begin
      n_hs = HS_NAK;
    end else if (pid_bad) begin
      n_hs = HS_ACK;
    end else begin
      n_hs = HS_ACK; n_push = 1'b1; n_tog = seq_ep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs <= HS_NONE; fifo_push <= 1'b0; pid_toggle <= 1'b0;
      set_nak_req <= 1'b0; clr_stall_req <= 1'b0;
    end else begin
      hs <= n_hs; fifo_push <= n_push; pid_toggle <= n_tog;
      set_nak_req <= n_snak; clr_stall_req <= n_cstl;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end |=> (hs == HS_NONE && !fifo_push && !pid_toggle && !set_nak_req && !clr_stall_req));

  // R4
  setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && tok_setup && (crc_ok || snoop) && pkt_len <= max_pkt)
      |=> (hs == HS_ACK && fifo_push && set_nak_req && !pid_toggle));

  // R6
  stall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !tok_setup && (crc_ok || snoop) && pkt_len <= max_pkt && ep_type != T_ISO && ep_stall)
      |=> (hs == HS_STALL && !fifo_push));

  // R9
  toggle_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pid_toggle |-> (hs == HS_ACK && fifo_push));

  // R7
  push_not_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (hs == HS_ACK || hs == HS_NONE));

  // R4
  clr_with_setnak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stall_req |-> set_nak_req);
endmodule

// File: tb/test_usb_out_hs_resp.sv
module test_usb_out_hs_resp;
  localparam int LEN_W = 11, FREE_W = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_end = 0, tok_setup = 0, data_pid = 0, crc_ok = 0;
  logic [LEN_W-1:0] pkt_len = '0, max_pkt = 11'd64;
  logic [FREE_W-1:0] fifo_free = '0;
  logic ep_enable = 0, ep_nak = 0, glob_out_nak = 0, ep_stall = 0, snoop = 0, exp_pid = 0;
  logic [1:0] ep_type = 2'b00;
  logic [1:0] hs;
  logic fifo_push, pid_toggle, set_nak_req, clr_stall_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_out_hs_resp #(.LEN_W(LEN_W), .FREE_W(FREE_W)) i_usb_out_hs_resp (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .tok_setup(tok_setup), .data_pid(data_pid),
    .crc_ok(crc_ok), .pkt_len(pkt_len), .fifo_free(fifo_free), .ep_enable(ep_enable),
    .ep_nak(ep_nak), .glob_out_nak(glob_out_nak), .ep_stall(ep_stall), .snoop(snoop),
    .ep_type(ep_type), .exp_pid(exp_pid), .max_pkt(max_pkt), .hs(hs), .fifo_push(fifo_push),
    .pid_toggle(pid_toggle), .set_nak_req(set_nak_req), .clr_stall_req(clr_stall_req));

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got hs/push/tog/snak/cstl=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model(output string req);
    logic [1:0] h; logic p, t, sn, cs;
    bit fit;
    h = 2'b00; p = 0; t = 0; sn = 0; cs = 0;
    fit = int'(fifo_free) >= int'(pkt_len);
    if (!crc_ok && !snoop) req = snoop ? "R10" : "R2";
    else if (pkt_len > max_pkt) req = "R3";
    else if (tok_setup) begin
      req = "R4"; h = 2'b01; p = 1; sn = 1; cs = (ep_type == 2'b00);
    end else if (ep_type == 2'b01) begin
      req = "R5"; p = fit;
    end else if (ep_stall) begin
      req = "R6"; h = 2'b11;
    end else if (!ep_enable || ep_nak || glob_out_nak || !fit) begin
      req = "R7"; h = 2'b10;
    end else if (ep_type[1] && !snoop && data_pid != exp_pid) begin
      req = "R8"; h = 2'b01;
    end else begin
      req = (snoop && (!crc_ok || data_pid != exp_pid)) ? "R10" : "R9";
      h = 2'b01; p = 1; t = ep_type[1];
    end
    return {h, p, t, sn, cs};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got no end expected end");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    string req;
    logic [5:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {hs, fifo_push, pid_toggle, set_nak_req, clr_stall_req}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {hs, fifo_push, pid_toggle, set_nak_req, clr_stall_req}, 6'b0);
    for (int sz = 0; sz < 4; sz++) begin
      for (int c = 0; c < 2048; c++) begin
        {tok_setup, crc_ok, ep_nak, glob_out_nak, ep_stall, snoop, ep_enable,
         ep_type, data_pid, exp_pid} = 11'(c);
        case (sz)
          0: begin pkt_len = 11'd16;  fifo_free = 12'd32;  end
          1: begin pkt_len = 11'd64;  fifo_free = 12'd64;  end
          2: begin pkt_len = 11'd48;  fifo_free = 12'd20;  end
          default: begin pkt_len = 11'd65; fifo_free = 12'd200; end
        endcase
        pkt_end = 1'b1;
        exp = model(req);
        @(negedge clk);
        pkt_end = 1'b0;
        check(req, {hs, fifo_push, pid_toggle, set_nak_req, clr_stall_req}, exp);
        @(negedge clk);
        // R1 response lasts one cycle only
        check("R1", {hs, fifo_push, pid_toggle, set_nak_req, clr_stall_req}, 6'b0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule